// File: doc/BRIEF.md
# I2C Status Flags and Write-One-to-Clear Acknowledge

This block keeps the interrupt status of an I2C peripheral. Three data-path flags follow the transmit and receive holding registers: transmit-holding-empty, transmit-request and receive-holding-full. Nine sticky event flags latch single-cycle pulses from the protocol engines: address match, NACK, stop, bus error, arbitration loss, overrun/underrun, packet-check error, timeout and alert. The shifter, timing and SMBus engines sit outside this block. They hand over bytes and event pulses through the ports below.

Software uses a small register bus. It reads the status word, writes to the status word to flush the transmit holding register or force a transmit request, and writes ones to an acknowledge word to clear event flags. Writing the transmit data address loads a byte. Reading the receive data address returns the received byte and marks it consumed. An interrupt line and two DMA request lines come from the flags and the enable inputs.

Top module: `i2c_flag_regs`

## Requirements
- R1: After reset, the status word (address 0x18) reads 0x0000_0001: bit 0 (transmit empty) is 1, every other bit is 0, and `irq_o`, `dma_tx_o` and `dma_rx_o` are 0.
- R2: A `rx_push_i` pulse stores `rx_byte_i` and sets status bit 2 in the next cycle. A bus read of the receive address (0x24) returns the byte and clears bit 2 in the next cycle. If a push and that read fall in the same cycle, bit 2 stays 1.
- R3: A bus write to the transmit address (0x28) loads `bus_wdata_i[7:0]` onto `tx_byte_o` and clears status bits 0 and 1 in the next cycle. A `tx_take_i` pulse while bit 0 is 0 sets both bits. A write in the same cycle as a take wins.
- R4: Writing the status word with bit 0 = 1 sets status bit 0 and drops the pending byte, so `tx_byte_o` becomes 0.
- R5: Writing the status word with bit 1 = 1 sets status bit 1 only while `nostretch_i` is 1. Otherwise the write leaves bit 1 unchanged. Other written status bits have no effect.
- R6: While `pe_i` is 0, the next cycle shows status bit 0 = 1, bit 1 = 0 and bit 2 = 0, whatever else happens. Event flags and holding bytes are not affected.
- R7: An `evt_i[k]` pulse at an event position (3 address, 4 NACK, 5 stop, 8 bus error, 9 arbitration lost, 10 overrun, 11 packet check, 12 timeout, 13 alert) sets status bit k until a 1 is written to bit k of the acknowledge word (0x1C). Writing 0 there has no effect.
- R8: When an event pulse and its clear fall in the same cycle, the flag ends set.
- R9: Acknowledge bits outside the event positions have no effect, `evt_i` bits 0 to 2 and 6 to 7 are ignored, and the acknowledge word reads as 0.
- R10: With `SMBUS_EN` = 0, status bits 11 to 13 never set and their acknowledge bits do nothing.
- R11: `irq_o` is 1 when any status bit k and `irq_en_i[k]` are both 1. `dma_tx_o` is status bit 1 AND `dma_tx_en_i`. `dma_rx_o` is status bit 2 AND `dma_rx_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pe_i | input | 1 | Peripheral enable |
| nostretch_i | input | 1 | Clock stretching disabled; allows a forced transmit request |
| irq_en_i | input | 14 | Per-status-bit interrupt enable |
| dma_tx_en_i | input | 1 | Transmit DMA request enable |
| dma_rx_en_i | input | 1 | Receive DMA request enable |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Bus write (1) or read (0) |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data; 0 when no read is selected |
| tx_take_i | input | 1 | Shifter consumed the transmit byte |
| tx_byte_o | output | 8 | Transmit holding register |
| rx_push_i | input | 1 | Shifter delivers a received byte |
| rx_byte_i | input | 8 | Received byte |
| evt_i | input | 14 | Event pulses, one per status bit position |
| irq_o | output | 1 | Interrupt request |
| dma_tx_o | output | 1 | Transmit DMA request |
| dma_rx_o | output | 1 | Receive DMA request |

## Verification
Directed sequences place the colliding pairs side by side in one cycle: push with read, take with write, event with its clear. This separates a set-wins design from a clear-wins one. They also write the status word with and without the no-stretch input, and drop the enable mid-traffic, so the forced flags can be told apart from the hardware-driven ones. A long random run then mixes bus writes with all-random data to every address, including an unmapped one, together with sparse event pulses and shifter traffic. It is compared each cycle against a bench model, on both the SMBus-enabled and SMBus-disabled builds, so that reserved-bit leaks and missing masks show up in the read data and the request lines.

// File: rtl/i2c_flag_pkg.sv
`timescale 1ns/1ps
package i2c_flag_pkg;

    localparam int FLAG_W = 14;

    // Status and acknowledge bit positions (shared by both words)
    localparam int B_TX_EMPTY = 0;
    localparam int B_TX_REQ   = 1;
    localparam int B_RX_FULL  = 2;

    // Event positions always present: 3,4,5 and 8,9,10
    localparam logic [FLAG_W-1:0] CORE_EVT_MASK = 14'b00_0111_0011_1000;
    // Event positions present only with SMBus support: 11,12,13
    localparam logic [FLAG_W-1:0] SMB_EVT_MASK  = 14'b11_1000_0000_0000;

    typedef struct packed {
        logic wr_tx;
        logic wr_stat;
        logic wr_clr;
        logic rd_rx;
    } bus_cmd_t;

endpackage

// File: rtl/i2c_flag_bus.sv
`timescale 1ns/1ps
module i2c_flag_bus
    import i2c_flag_pkg::*;
#(
    parameter int          AW        = 8,
    parameter int          DW        = 32,
    parameter int          BW        = 8,
    parameter logic [7:0]  STAT_ADDR = 8'h18,
    parameter logic [7:0]  CLR_ADDR  = 8'h1C,
    parameter logic [7:0]  RX_ADDR   = 8'h24,
    parameter logic [7:0]  TX_ADDR   = 8'h28
) (
    input  logic              sel_i,
    input  logic              we_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [FLAG_W-1:0] status_i,
    input  logic [BW-1:0]     rx_byte_i,
    output bus_cmd_t          cmd_o,
    output logic [DW-1:0]     rdata_o
);

    logic hit_stat, hit_clr, hit_rx, hit_tx;

    always_comb begin
        hit_stat = (addr_i == AW'(STAT_ADDR));
        hit_clr  = (addr_i == AW'(CLR_ADDR));
        hit_rx   = (addr_i == AW'(RX_ADDR));
        hit_tx   = (addr_i == AW'(TX_ADDR));

        cmd_o         = '0;
        cmd_o.wr_tx   = sel_i &  we_i & hit_tx;
        cmd_o.wr_stat = sel_i &  we_i & hit_stat;
        cmd_o.wr_clr  = sel_i &  we_i & hit_clr;
        cmd_o.rd_rx   = sel_i & ~we_i & hit_rx;

        // Acknowledge and transmit addresses are write-only: they read as zero
        rdata_o = '0;
        if (sel_i && !we_i) begin
            if (hit_stat)
                rdata_o[FLAG_W-1:0] = status_i;
            else if (hit_rx)
                rdata_o[BW-1:0] = rx_byte_i;
        end
    end

endmodule

// File: rtl/i2c_data_flags.sv
`timescale 1ns/1ps
module i2c_data_flags
    import i2c_flag_pkg::*;
#(
    parameter int BW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          pe_i,
    input  logic          nostretch_i,
    input  bus_cmd_t      cmd_i,
    input  logic [BW-1:0] wdata_i,
    input  logic          tx_take_i,
    input  logic          rx_push_i,
    input  logic [BW-1:0] rx_byte_i,
    output logic          tx_empty_o,
    output logic          tx_req_o,
    output logic          rx_full_o,
    output logic [BW-1:0] tx_byte_o,
    output logic [BW-1:0] rx_byte_o
);

    typedef struct packed {
        logic          tx_empty;
        logic          tx_req;
        logic          rx_full;
        logic [BW-1:0] tx_byte;
        logic [BW-1:0] rx_byte;
    } dflag_t;

    dflag_t st_d, st_q;

    always_comb begin
        st_d = st_q;

        // Transmit side: a new byte beats a take in the same cycle
        if (cmd_i.wr_tx) begin
            st_d.tx_byte  = wdata_i;
            st_d.tx_empty = 1'b0;
            st_d.tx_req   = 1'b0;
        end else if (tx_take_i && !st_q.tx_empty) begin
            st_d.tx_empty = 1'b1;
            st_d.tx_req   = 1'b1;
        end

        // Software flush discards the pending byte
        if (cmd_i.wr_stat && wdata_i[B_TX_EMPTY]) begin
            st_d.tx_empty = 1'b1;
            st_d.tx_byte  = '0;
        end

        // Forced transmit request only without clock stretching
        if (cmd_i.wr_stat && wdata_i[B_TX_REQ] && nostretch_i)
            st_d.tx_req = 1'b1;

        // Receive side: arrival beats consumption
        if (rx_push_i) begin
            st_d.rx_full = 1'b1;
            st_d.rx_byte = rx_byte_i;
        end else if (cmd_i.rd_rx) begin
            st_d.rx_full = 1'b0;
        end

        // Disabled peripheral overrides the data flags
        if (!pe_i) begin
            st_d.tx_empty = 1'b1;
            st_d.tx_req   = 1'b0;
            st_d.rx_full  = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q          <= '0;
            st_q.tx_empty <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_empty_o = st_q.tx_empty;
    assign tx_req_o   = st_q.tx_req;
    assign rx_full_o  = st_q.rx_full;
    assign tx_byte_o  = st_q.tx_byte;
    assign rx_byte_o  = st_q.rx_byte;

endmodule

// File: rtl/i2c_event_flags.sv
`timescale 1ns/1ps
module i2c_event_flags
    import i2c_flag_pkg::*;
#(
    parameter bit SMBUS_EN = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [FLAG_W-1:0] evt_i,
    input  logic              clr_stb_i,
    input  logic [FLAG_W-1:0] clr_bits_i,
    output logic [FLAG_W-1:0] flags_o
);

    logic [FLAG_W-1:0] live_mask;
    logic [FLAG_W-1:0] clr_vec;
    logic [FLAG_W-1:0] flg_d, flg_q;

    generate
        if (SMBUS_EN) begin : g_smb_on
            assign live_mask = CORE_EVT_MASK | SMB_EVT_MASK;
        end else begin : g_smb_off
            assign live_mask = CORE_EVT_MASK;
        end
    endgenerate

    always_comb begin
        clr_vec = clr_stb_i ? clr_bits_i : '0;
        // Set has priority over a clear in the same cycle
        flg_d   = (evt_i | (flg_q & ~clr_vec)) & live_mask;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flg_q <= '0;
        else         flg_q <= flg_d;
    end

    assign flags_o = flg_q;

endmodule

// File: rtl/i2c_flag_regs.sv
`timescale 1ns/1ps
module i2c_flag_regs
    import i2c_flag_pkg::*;
#(
    parameter int          AW        = 8,
    parameter int          DW        = 32,
    parameter int          BW        = 8,
    parameter bit          SMBUS_EN  = 1'b1,
    parameter logic [7:0]  STAT_ADDR = 8'h18,
    parameter logic [7:0]  CLR_ADDR  = 8'h1C,
    parameter logic [7:0]  RX_ADDR   = 8'h24,
    parameter logic [7:0]  TX_ADDR   = 8'h28
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              pe_i,
    input  logic              nostretch_i,
    input  logic [FLAG_W-1:0] irq_en_i,
    input  logic              dma_tx_en_i,
    input  logic              dma_rx_en_i,
    input  logic              bus_sel_i,
    input  logic              bus_we_i,
    input  logic [AW-1:0]     bus_addr_i,
    input  logic [DW-1:0]     bus_wdata_i,
    output logic [DW-1:0]     bus_rdata_o,
    input  logic              tx_take_i,
    output logic [BW-1:0]     tx_byte_o,
    input  logic              rx_push_i,
    input  logic [BW-1:0]     rx_byte_i,
    input  logic [FLAG_W-1:0] evt_i,
    output logic              irq_o,
    output logic              dma_tx_o,
    output logic              dma_rx_o
);

    bus_cmd_t          cmd;
    logic              tx_empty, tx_req, rx_full;
    logic [BW-1:0]     rx_hold;
    logic [FLAG_W-1:0] evt_flags;
    logic [FLAG_W-1:0] status_w;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata_i[DW-1:FLAG_W];

    i2c_flag_bus #(
        .AW(AW), .DW(DW), .BW(BW),
        .STAT_ADDR(STAT_ADDR), .CLR_ADDR(CLR_ADDR),
        .RX_ADDR(RX_ADDR), .TX_ADDR(TX_ADDR)
    ) u_bus (
        .sel_i    (bus_sel_i),
        .we_i     (bus_we_i),
        .addr_i   (bus_addr_i),
        .status_i (status_w),
        .rx_byte_i(rx_hold),
        .cmd_o    (cmd),
        .rdata_o  (bus_rdata_o)
    );

    i2c_data_flags #(.BW(BW)) u_data (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .pe_i       (pe_i),
        .nostretch_i(nostretch_i),
        .cmd_i      (cmd),
        .wdata_i    (bus_wdata_i[BW-1:0]),
        .tx_take_i  (tx_take_i),
        .rx_push_i  (rx_push_i),
        .rx_byte_i  (rx_byte_i),
        .tx_empty_o (tx_empty),
        .tx_req_o   (tx_req),
        .rx_full_o  (rx_full),
        .tx_byte_o  (tx_byte_o),
        .rx_byte_o  (rx_hold)
    );

    i2c_event_flags #(.SMBUS_EN(SMBUS_EN)) u_evt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .evt_i     (evt_i),
        .clr_stb_i (cmd.wr_clr),
        .clr_bits_i(bus_wdata_i[FLAG_W-1:0]),
        .flags_o   (evt_flags)
    );

    always_comb begin
        status_w = evt_flags;
        status_w[B_TX_EMPTY] = status_w[B_TX_EMPTY] | tx_empty;
        status_w[B_TX_REQ]   = status_w[B_TX_REQ]   | tx_req;
        status_w[B_RX_FULL]  = status_w[B_RX_FULL]  | rx_full;
    end

    assign irq_o    = |(status_w & irq_en_i);
    assign dma_tx_o = tx_req  & dma_tx_en_i;
    assign dma_rx_o = rx_full & dma_rx_en_i;

endmodule

// File: rtl/i2c_flag_regs_chk.sv
`timescale 1ns/1ps
module i2c_flag_regs_chk
    import i2c_flag_pkg::*;
#(
    parameter int          AW        = 8,
    parameter int          DW        = 32,
    parameter bit          SMBUS_EN  = 1'b1,
    parameter logic [7:0]  STAT_ADDR = 8'h18,
    parameter logic [7:0]  CLR_ADDR  = 8'h1C,
    parameter logic [7:0]  TX_ADDR   = 8'h28
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              pe_i,
    input logic              nostretch_i,
    input logic              bus_sel_i,
    input logic              bus_we_i,
    input logic [AW-1:0]     bus_addr_i,
    input logic [DW-1:0]     bus_wdata_i,
    input logic              tx_take_i,
    input logic              rx_push_i,
    input logic [FLAG_W-1:0] evt_i,
    input logic [FLAG_W-1:0] status
);

    logic wr_stat, wr_clr, wr_tx;
    assign wr_stat = bus_sel_i && bus_we_i && (bus_addr_i == AW'(STAT_ADDR));
    assign wr_clr  = bus_sel_i && bus_we_i && (bus_addr_i == AW'(CLR_ADDR));
    assign wr_tx   = bus_sel_i && bus_we_i && (bus_addr_i == AW'(TX_ADDR));

    a_r2_push_sets_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pe_i && rx_push_i) |=> status[2]);

    a_r3_tx_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pe_i && wr_tx) |=> (!status[0] && !status[1]));

    a_r5_force_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_stat && bus_wdata_i[1] && !nostretch_i && !status[1] && !tx_take_i) |=> !status[1]);

    a_r6_disable_forces: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pe_i |=> (status[0] && !status[1] && !status[2]));

    a_r7_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_i[4] |=> status[4]);

    a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_i[5] && wr_clr && bus_wdata_i[5]) |=> status[5]);

    a_r7_clear_works: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_clr && bus_wdata_i[3] && !evt_i[3]) |=> !status[3]);

    generate
        if (!SMBUS_EN) begin : g_no_smb
            a_r10_smb_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
                status[13:11] == 3'b000);
        end
    endgenerate

endmodule

bind i2c_flag_regs i2c_flag_regs_chk #(
    .AW(AW), .DW(DW), .SMBUS_EN(SMBUS_EN),
    .STAT_ADDR(STAT_ADDR), .CLR_ADDR(CLR_ADDR), .TX_ADDR(TX_ADDR)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pe_i       (pe_i),
    .nostretch_i(nostretch_i),
    .bus_sel_i  (bus_sel_i),
    .bus_we_i   (bus_we_i),
    .bus_addr_i (bus_addr_i),
    .bus_wdata_i(bus_wdata_i),
    .tx_take_i  (tx_take_i),
    .rx_push_i  (rx_push_i),
    .evt_i      (evt_i),
    .status     (status_w)
);

// File: tb/tb_i2c_flag_regs.sv
`timescale 1ns/1ps
module tb_i2c_flag_regs;

    localparam logic [7:0] A_STAT = 8'h18;
    localparam logic [7:0] A_CLR  = 8'h1C;
    localparam logic [7:0] A_RX   = 8'h24;
    localparam logic [7:0] A_TX   = 8'h28;
    localparam logic [13:0] LIVE_FULL  = 14'b11_1111_0011_1000;
    localparam logic [13:0] LIVE_NOSMB = 14'b00_0111_0011_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pe, nostretch, dma_tx_en, dma_rx_en;
    logic [13:0] irq_en, evt;
    logic        sel, we, tx_take, rx_push;
    logic [7:0]  addr, rx_byte;
    logic [31:0] wdata;
    logic [31:0] rdata, rdata2;
    logic [7:0]  tx_byte, tx_byte2;
    logic        irq, dma_tx, dma_rx, irq2, dma_tx2, dma_rx2;

    int n_chk = 0;
    int n_fail = 0;

    // Bench model state
    logic        m_te, m_tr, m_rf;
    logic [7:0]  m_txb, m_rxb;
    logic [13:0] m_ev, m2_ev;

    always #2.5 clk = ~clk;

    i2c_flag_regs dut (
        .clk_i(clk), .rst_ni(rst_n), .pe_i(pe), .nostretch_i(nostretch),
        .irq_en_i(irq_en), .dma_tx_en_i(dma_tx_en), .dma_rx_en_i(dma_rx_en),
        .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .tx_take_i(tx_take), .tx_byte_o(tx_byte),
        .rx_push_i(rx_push), .rx_byte_i(rx_byte), .evt_i(evt),
        .irq_o(irq), .dma_tx_o(dma_tx), .dma_rx_o(dma_rx)
    );

    i2c_flag_regs #(.SMBUS_EN(1'b0)) dut_nosmb (
        .clk_i(clk), .rst_ni(rst_n), .pe_i(pe), .nostretch_i(nostretch),
        .irq_en_i(irq_en), .dma_tx_en_i(dma_tx_en), .dma_rx_en_i(dma_rx_en),
        .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata2), .tx_take_i(tx_take), .tx_byte_o(tx_byte2),
        .rx_push_i(rx_push), .rx_byte_i(rx_byte), .evt_i(evt),
        .irq_o(irq2), .dma_tx_o(dma_tx2), .dma_rx_o(dma_rx2)
    );

    function automatic logic [13:0] stat_of(input logic [13:0] ev);
        return ev | {11'b0, m_rf, m_tr, m_te};
    endfunction

    function automatic logic [31:0] exp_rd(input logic [13:0] ev);
        logic [31:0] r = '0;
        if (sel && !we) begin
            if (addr == A_STAT)    r[13:0] = stat_of(ev);
            else if (addr == A_RX) r[7:0]  = m_rxb;
        end
        return r;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_next();
        logic wr = sel && we;
        logic [13:0] clrv;
        if (wr && addr == A_TX) begin
            m_txb = wdata[7:0]; m_te = 1'b0; m_tr = 1'b0;
        end else if (tx_take && !m_te) begin
            m_te = 1'b1; m_tr = 1'b1;
        end
        if (wr && addr == A_STAT && wdata[0]) begin m_te = 1'b1; m_txb = '0; end
        if (wr && addr == A_STAT && wdata[1] && nostretch) m_tr = 1'b1;
        if (rx_push) begin m_rf = 1'b1; m_rxb = rx_byte; end
        else if (sel && !we && addr == A_RX) m_rf = 1'b0;
        if (!pe) begin m_te = 1'b1; m_tr = 1'b0; m_rf = 1'b0; end
        clrv  = (wr && addr == A_CLR) ? wdata[13:0] : 14'b0;
        m_ev  = (evt | (m_ev  & ~clrv)) & LIVE_FULL;
        m2_ev = (evt | (m2_ev & ~clrv)) & LIVE_NOSMB;
    endtask

    // Inputs are set just after a falling edge; outputs checked, then one clock
    task automatic step(input string req);
        #1;
        check(req, "rdata",       rdata,  exp_rd(m_ev));
        check(req, "rdata_nosmb", rdata2, exp_rd(m2_ev));
        check(req, "tx_byte",     {24'b0, tx_byte},  {24'b0, m_txb});
        check(req, "tx_byte_ns",  {24'b0, tx_byte2}, {24'b0, m_txb});
        check(req, "irq",         {31'b0, irq},  {31'b0, |(stat_of(m_ev)  & irq_en)});
        check(req, "irq_nosmb",   {31'b0, irq2}, {31'b0, |(stat_of(m2_ev) & irq_en)});
        check(req, "dma_tx",      {31'b0, dma_tx}, {31'b0, m_tr & dma_tx_en});
        check(req, "dma_rx",      {31'b0, dma_rx}, {31'b0, m_rf & dma_rx_en});
        model_next();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        sel = 1'b0; we = 1'b0; addr = 8'h00; wdata = '0;
        tx_take = 1'b0; rx_push = 1'b0; rx_byte = '0; evt = '0;
    endtask

    task automatic bus(input logic w, input logic [7:0] a, input logic [31:0] d);
        sel = 1'b1; we = w; addr = a; wdata = d;
    endtask

    task automatic rd_stat(input string req);
        idle(); bus(1'b0, A_STAT, 32'h0); step(req);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    logic [7:0] addr_pool [5];

    initial begin
        addr_pool[0] = A_STAT; addr_pool[1] = A_CLR; addr_pool[2] = A_RX;
        addr_pool[3] = A_TX;   addr_pool[4] = 8'h20;
        void'($urandom(32'h5EED_1C2C));
        pe = 1'b1; nostretch = 1'b0; irq_en = '0; dma_tx_en = 1'b0; dma_rx_en = 1'b0;
        idle();
        m_te = 1'b1; m_tr = 1'b0; m_rf = 1'b0; m_txb = '0; m_rxb = '0; m_ev = '0; m2_ev = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, all request lines low with full enables
        irq_en = 14'h3FFE; dma_tx_en = 1'b1; dma_rx_en = 1'b1;
        rd_stat("R1");

        // R2: receive push, read-back, and push colliding with read
        idle(); rx_push = 1'b1; rx_byte = 8'hA5; step("R2");
        rd_stat("R2");
        idle(); bus(1'b0, A_RX, 0); step("R2");
        rd_stat("R2");
        idle(); rx_push = 1'b1; rx_byte = 8'h3C; step("R2");
        idle(); bus(1'b0, A_RX, 0); rx_push = 1'b1; rx_byte = 8'h5A; step("R2");
        rd_stat("R2");

        // R3: transmit load, take, and write colliding with take
        idle(); bus(1'b1, A_TX, 32'h0000_0042); step("R3");
        rd_stat("R3");
        idle(); tx_take = 1'b1; step("R3");
        rd_stat("R3");
        idle(); bus(1'b1, A_TX, 32'h0000_0091); step("R3");
        idle(); bus(1'b1, A_TX, 32'h0000_0017); tx_take = 1'b1; step("R3");
        rd_stat("R3");

        // R4: flush drops the pending byte
        idle(); bus(1'b1, A_STAT, 32'h0000_0001); step("R4");
        rd_stat("R4");

        // R5: forced request needs no-stretch; other status bits ignored
        idle(); bus(1'b1, A_TX, 32'h0000_0066); step("R5");
        nostretch = 1'b0;
        idle(); bus(1'b1, A_STAT, 32'h0000_3FFE); step("R5");
        rd_stat("R5");
        nostretch = 1'b1;
        idle(); bus(1'b1, A_STAT, 32'h0000_0002); step("R5");
        rd_stat("R5");

        // R6: disable forces data flags, keeps events
        idle(); evt = 14'h0010; rx_push = 1'b1; rx_byte = 8'h81; step("R6");
        pe = 1'b0; idle(); step("R6");
        rd_stat("R6");
        pe = 1'b1;

        // R7: event latch, zero write, then clear
        idle(); evt = 14'h0008; step("R7");
        idle(); bus(1'b1, A_CLR, 32'h0); step("R7");
        rd_stat("R7");
        idle(); bus(1'b1, A_CLR, 32'h0000_0018); step("R7");
        rd_stat("R7");

        // R8: set beats clear in the same cycle
        idle(); evt = 14'h0020; step("R8");
        idle(); evt = 14'h0020; bus(1'b1, A_CLR, 32'h0000_0020); step("R8");
        rd_stat("R8");

        // R9: reserved acknowledge bits, ignored event inputs, zero read
        idle(); evt = 14'h00C7; step("R9");
        idle(); bus(1'b1, A_CLR, 32'hFFFF_C0C7); step("R9");
        idle(); bus(1'b0, A_CLR, 0); step("R9");
        rd_stat("R9");

        // R10: SMBus positions on both builds, then cleared
        idle(); evt = 14'h3800; step("R10");
        rd_stat("R10");
        idle(); bus(1'b1, A_CLR, 32'h0000_3820); step("R10");
        rd_stat("R10");

        // R11: single-bit interrupt enables and DMA gating
        irq_en = 14'h0004; dma_tx_en = 1'b0;
        idle(); rx_push = 1'b1; rx_byte = 8'h11; step("R11");
        rd_stat("R11");
        irq_en = 14'h0000; dma_rx_en = 1'b0; rd_stat("R11");
        dma_tx_en = 1'b1; idle(); bus(1'b1, A_STAT, 32'h2); step("R11");
        rd_stat("R11");

        // Random mix checked every cycle against the bench model
        for (int i = 0; i < 4000; i++) begin
            pe        = ($urandom % 20) != 0;
            nostretch = $urandom % 2;
            irq_en    = 14'($urandom);
            dma_tx_en = $urandom % 2;
            dma_rx_en = $urandom % 2;
            sel       = $urandom % 2;
            we        = $urandom % 2;
            addr      = addr_pool[$urandom % 5];
            wdata     = $urandom;
            tx_take   = ($urandom % 4) == 0;
            rx_push   = ($urandom % 4) == 0;
            rx_byte   = 8'($urandom);
            evt       = 14'($urandom & $urandom & $urandom);
            step("R11-rand");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule